// File: doc/BRIEF.md
# Debug Control and Flag Register Pair

This block keeps two 8-bit registers that pass state between a JTAG-side debug engine and the CPU's special-function-register bus. The control register holds the host command that the debug engine has loaded and the debug-mode enable bit that gates breakpoints. The flag register holds a transfer-complete handshake bit and a program-enable bit. The CPU reads that program-enable bit as the OR of a local copy and a copy kept on the TAP side.

Each bit has one owner. The debug engine loads the command and the debug-mode enable, sets the local program-enable bit and clears transfer complete. The TAP link sets transfer complete. The CPU can only reach the transfer-complete bit. Any CPU write to the flag register also sends a one-cycle pulse that clears the TAP status pair. After each command load that names a supported operation, the block raises a one-cycle strobe so the handler can act on it.

Top module: `dbg_ctl_flag_regs`

## Requirements
- R1: An active-low `rst_n`, or `tap_tlr` high at a clock edge (which wins over every write in that cycle), clears every bit of both registers. Both also clear the TAP-side program-enable copy, `cmd_valid` and `pss_clr`.
- R2: The command field (control bits 3:0, output on `cmd_code`) changes only when `de_cmd_we` is high, and then takes `de_cmd`. A CPU write to the control register (`cpu_sel`=0) changes no bit.
- R3: Control bits 6:4 always read as 0.
- R4: Control bit 7 (debug-mode enable, output on `bkpt_en`; 1 enables breakpoints) takes `de_dme` on `de_dme_we` only while `bg_mode` is 1. At all other times it holds its value.
- R5: Flag bit 0 (transfer complete) is set by `tap_xfer_done` and cleared by `de_txc_clr`. When both come in the same cycle, the set wins, and it also wins over a CPU write.
- R6: A CPU write to the flag register (`cpu_sel`=1) loads `cpu_wdata[0]` into flag bit 0 and ignores bits 7:1. In the next cycle, and only then, `pss_clr` is 1.
- R7: Flag bit 1 reads as the OR of the local program-enable bit (set by `de_spe_set`, cleared only by R1) and the TAP-side bit. The CPU cannot write it. Flag bits 7:2 read as 0.
- R8: The TAP-side program-enable bit is loaded from `tap_spe_din` on `tap_spe_we`. `tap_rod` clears it and wins over a load in the same cycle.
- R9: `cmd_valid` is 1 for exactly the one cycle after a `de_cmd_we` whose code is 0000 to 1001, or 1010 while `test_mode_en` is 1. For the reserved codes 1011 to 1111, and for 1010 with test mode off, it stays 0.
- R10: `rdata` is combinational. It returns the control register when `cpu_sel`=0 and the flag register when `cpu_sel`=1, and is 0 while `cpu_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| tap_tlr | input | 1 | TAP is in Test-Logic-Reset; synchronous clear |
| de_cmd_we | input | 1 | Debug engine loads the command field |
| de_cmd | input | 4 | Command code to load |
| de_dme_we | input | 1 | Debug engine writes the debug-mode enable |
| de_dme | input | 1 | New debug-mode enable value |
| de_txc_clr | input | 1 | Debug engine clears transfer complete |
| de_spe_set | input | 1 | Debug engine sets the local program-enable bit |
| tap_xfer_done | input | 1 | Pulse at the end of a TAP transfer cycle |
| tap_spe_we | input | 1 | Load the TAP-side program-enable bit |
| tap_spe_din | input | 1 | Value for the TAP-side program-enable bit |
| tap_rod | input | 1 | Clears the TAP-side program-enable bit |
| bg_mode | input | 1 | Background mode is active |
| test_mode_en | input | 1 | Test-execute command permitted |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_sel | input | 1 | Register select: 0 control, 1 flag |
| cpu_wdata | input | 8 | CPU write data |
| rdata | output | 8 | Read data for the selected register |
| cmd_code | output | 4 | Current command field |
| cmd_valid | output | 1 | One-cycle strobe after a supported command load |
| bkpt_en | output | 1 | Breakpoints enabled |
| pss_clr | output | 1 | One-cycle clear pulse for the TAP status pair |

## Verification
Some rules can be checked on every cycle, and the assertions do so. After a TAP reset all state reads zero. The reserved control bits read as zero on every control read. The debug-mode enable holds while background mode is off. A transfer-complete set always lands, whatever else arrives with it. ROD leaves the TAP-side bit clear. The clear pulse follows exactly the flag writes. A strobe only ever follows a command load, and never follows a reserved code.

Other rules need a sequence of stimulus, so only the bench scenarios can show them. These are: that CPU writes to the control register and to flag bits 7:1 change nothing seen on a later read; the exact value for every one of the sixteen command codes under both test-mode settings; and the OR of the two program-enable copies as each is set and cleared in turn.

// File: rtl/dbg_regs_pkg.sv
package dbg_regs_pkg;

  localparam int REG_W = 8;
  localparam int CMD_W = 4;

  // Bit positions that the read path and the owners agree on
  localparam int CTL_DME_BIT = 7;
  localparam int FLG_TXC_BIT = 0;
  localparam int FLG_SPE_BIT = 1;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP      = 4'b0000,
    CMD_RD_REG   = 4'b0001,
    CMD_RD_DATA  = 4'b0010,
    CMD_RD_STACK = 4'b0011,
    CMD_WR_REG   = 4'b0100,
    CMD_WR_DATA  = 4'b0101,
    CMD_STEP     = 4'b0110,
    CMD_RETURN   = 4'b0111,
    CMD_UNLOCK   = 4'b1000,
    CMD_RD_SEL   = 4'b1001,
    CMD_EXEC_TST = 4'b1010
  } dbg_cmd_e;

  // Is a loaded code one the handler may act on?
  function automatic logic cmd_supported(input logic [CMD_W-1:0] code,
                                         input logic test_ok);
    logic ok;
    ok = 1'b0;
    if (code <= CMD_W'(CMD_RD_SEL)) ok = 1'b1;
    else if (code == CMD_W'(CMD_EXEC_TST)) ok = test_ok;
    return ok;
  endfunction

  // Control register image as the CPU sees it
  function automatic logic [REG_W-1:0] ctl_image(input logic [CMD_W-1:0] cmd,
                                                 input logic dme);
    logic [REG_W-1:0] img;
    img = '0;
    img[CMD_W-1:0] = cmd;
    img[CTL_DME_BIT] = dme;
    return img;
  endfunction

  // Flag register image as the CPU sees it
  function automatic logic [REG_W-1:0] flg_image(input logic txc,
                                                 input logic spe_loc,
                                                 input logic spe_tap);
    logic [REG_W-1:0] img;
    img = '0;
    img[FLG_TXC_BIT] = txc;
    img[FLG_SPE_BIT] = spe_loc | spe_tap;
    return img;
  endfunction

endpackage

// File: rtl/dbg_ctl_reg.sv
module dbg_ctl_reg
  import dbg_regs_pkg::*;
#(
  parameter int CW = CMD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tlr,
  input  logic          cmd_we,
  input  logic [CW-1:0] cmd_din,
  input  logic          dme_we,
  input  logic          dme_din,
  input  logic          bg_mode,
  input  logic          test_ok,
  output logic [CW-1:0] cmd_q,
  output logic          dme_q,
  output logic          cmd_strobe
);

  logic dme_upd;
  logic strobe_nxt;

  assign dme_upd    = dme_we & bg_mode;
  assign strobe_nxt = cmd_we & cmd_supported(CMD_W'(cmd_din), test_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= '0;
      dme_q      <= 1'b0;
      cmd_strobe <= 1'b0;
    end else if (tlr) begin
      cmd_q      <= '0;
      dme_q      <= 1'b0;
      cmd_strobe <= 1'b0;
    end else begin
      if (cmd_we)  cmd_q <= cmd_din;
      if (dme_upd) dme_q <= dme_din;
      cmd_strobe <= strobe_nxt;
    end
  end

endmodule

// File: rtl/dbg_flag_reg.sv
module dbg_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic tlr,
  input  logic xfer_done,
  input  logic de_clr,
  input  logic cpu_wr_flag,
  input  logic cpu_bit0,
  input  logic spe_set,
  input  logic tap_we,
  input  logic tap_din,
  input  logic rod,
  output logic txc_q,
  output logic spe_loc_q,
  output logic spe_tap_q,
  output logic pss_pulse
);

  logic txc_nxt;
  logic spe_tap_nxt;

  // Ownership priority: hardware set, then CPU write, then engine clear
  always_comb begin
    txc_nxt = txc_q;
    if (xfer_done)        txc_nxt = 1'b1;
    else if (cpu_wr_flag) txc_nxt = cpu_bit0;
    else if (de_clr)      txc_nxt = 1'b0;
  end

  always_comb begin
    spe_tap_nxt = spe_tap_q;
    if (rod)         spe_tap_nxt = 1'b0;
    else if (tap_we) spe_tap_nxt = tap_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txc_q     <= 1'b0;
      spe_loc_q <= 1'b0;
      spe_tap_q <= 1'b0;
      pss_pulse <= 1'b0;
    end else if (tlr) begin
      txc_q     <= 1'b0;
      spe_loc_q <= 1'b0;
      spe_tap_q <= 1'b0;
      pss_pulse <= 1'b0;
    end else begin
      txc_q     <= txc_nxt;
      spe_tap_q <= spe_tap_nxt;
      pss_pulse <= cpu_wr_flag;
      if (spe_set) spe_loc_q <= 1'b1;
    end
  end

endmodule

// File: rtl/dbg_rd_mux.sv
module dbg_rd_mux
  import dbg_regs_pkg::*;
#(
  parameter int DW = REG_W,
  parameter int CW = CMD_W
) (
  input  logic          rd,
  input  logic          sel_flag,
  input  logic [CW-1:0] cmd_q,
  input  logic          dme_q,
  input  logic          txc_q,
  input  logic          spe_loc_q,
  input  logic          spe_tap_q,
  output logic [DW-1:0] rdata
);

  logic [REG_W-1:0] ctl_img;
  logic [REG_W-1:0] flg_img;

  assign ctl_img = ctl_image(CMD_W'(cmd_q), dme_q);
  assign flg_img = flg_image(txc_q, spe_loc_q, spe_tap_q);

  always_comb begin
    rdata = '0;
    if (rd) rdata = sel_flag ? DW'(flg_img) : DW'(ctl_img);
  end

endmodule

// File: rtl/dbg_ctl_flag_regs.sv
module dbg_ctl_flag_regs
  import dbg_regs_pkg::*;
#(
  parameter int DATA_W = REG_W,
  parameter int CODE_W = CMD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tap_tlr,
  input  logic              de_cmd_we,
  input  logic [CODE_W-1:0] de_cmd,
  input  logic              de_dme_we,
  input  logic              de_dme,
  input  logic              de_txc_clr,
  input  logic              de_spe_set,
  input  logic              tap_xfer_done,
  input  logic              tap_spe_we,
  input  logic              tap_spe_din,
  input  logic              tap_rod,
  input  logic              bg_mode,
  input  logic              test_mode_en,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic              cpu_sel,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [CODE_W-1:0] cmd_code,
  output logic              cmd_valid,
  output logic              bkpt_en,
  output logic              pss_clr
);

  // Named internal events for the checker
  logic [CODE_W-1:0] cmd_q_w;
  logic              dme_q_w;
  logic              txc_q_w;
  logic              spe_loc_w;
  logic              spe_tap_w;
  logic              cpu_flag_wr_w;
  logic              unused_wdata_hi;

  assign cpu_flag_wr_w   = cpu_wr & cpu_sel;
  assign unused_wdata_hi = ^cpu_wdata[DATA_W-1:1];

  dbg_ctl_reg #(.CW(CODE_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .tlr       (tap_tlr),
    .cmd_we    (de_cmd_we),
    .cmd_din   (de_cmd),
    .dme_we    (de_dme_we),
    .dme_din   (de_dme),
    .bg_mode   (bg_mode),
    .test_ok   (test_mode_en),
    .cmd_q     (cmd_q_w),
    .dme_q     (dme_q_w),
    .cmd_strobe(cmd_valid)
  );

  dbg_flag_reg u_flg (
    .clk        (clk),
    .rst_n      (rst_n),
    .tlr        (tap_tlr),
    .xfer_done  (tap_xfer_done),
    .de_clr     (de_txc_clr),
    .cpu_wr_flag(cpu_flag_wr_w),
    .cpu_bit0   (cpu_wdata[0]),
    .spe_set    (de_spe_set),
    .tap_we     (tap_spe_we),
    .tap_din    (tap_spe_din),
    .rod        (tap_rod),
    .txc_q      (txc_q_w),
    .spe_loc_q  (spe_loc_w),
    .spe_tap_q  (spe_tap_w),
    .pss_pulse  (pss_clr)
  );

  dbg_rd_mux #(.DW(DATA_W), .CW(CODE_W)) u_rd (
    .rd       (cpu_rd),
    .sel_flag (cpu_sel),
    .cmd_q    (cmd_q_w),
    .dme_q    (dme_q_w),
    .txc_q    (txc_q_w),
    .spe_loc_q(spe_loc_w),
    .spe_tap_q(spe_tap_w),
    .rdata    (rdata)
  );

  assign cmd_code = cmd_q_w;
  assign bkpt_en  = dme_q_w;

endmodule

// File: rtl/dbg_ctl_flag_chk.sv
module dbg_ctl_flag_chk #(
  parameter int DATA_W = 8,
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tap_tlr,
  input logic              de_cmd_we,
  input logic [CODE_W-1:0] de_cmd,
  input logic              tap_xfer_done,
  input logic              tap_rod,
  input logic              bg_mode,
  input logic              cpu_rd,
  input logic              cpu_sel,
  input logic              cpu_flag_wr,
  input logic [DATA_W-1:0] rdata,
  input logic [CODE_W-1:0] cmd_q,
  input logic              dme_q,
  input logic              txc_q,
  input logic              spe_loc,
  input logic              spe_tap,
  input logic              cmd_valid,
  input logic              bkpt_en,
  input logic              pss_clr
);

  a_r1_tlr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    tap_tlr |=> (cmd_q == '0 && !dme_q && !txc_q && !spe_loc && !spe_tap));

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !cpu_sel) |-> (rdata[6:4] == 3'b000));

  a_r4_dme_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (!bg_mode && !tap_tlr) |=> $stable(bkpt_en));

  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_xfer_done && !tap_tlr) |=> txc_q);

  a_r6_pss_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_flag_wr && !tap_tlr) |=> pss_clr);

  a_r6_pss_only_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_flag_wr |=> !pss_clr);

  a_r7_flag_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_sel) |-> (rdata[DATA_W-1:2] == '0));

  a_r8_rod_clears: assert property (@(posedge clk) disable iff (!rst_n)
    tap_rod |=> !spe_tap);

  a_r9_strobe_source: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(de_cmd_we));

  a_r9_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (de_cmd_we && de_cmd > CODE_W'(10)) |=> !cmd_valid);

endmodule

bind dbg_ctl_flag_regs dbg_ctl_flag_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tap_tlr      (tap_tlr),
  .de_cmd_we    (de_cmd_we),
  .de_cmd       (de_cmd),
  .tap_xfer_done(tap_xfer_done),
  .tap_rod      (tap_rod),
  .bg_mode      (bg_mode),
  .cpu_rd       (cpu_rd),
  .cpu_sel      (cpu_sel),
  .cpu_flag_wr  (cpu_flag_wr_w),
  .rdata        (rdata),
  .cmd_q        (cmd_q_w),
  .dme_q        (dme_q_w),
  .txc_q        (txc_q_w),
  .spe_loc      (spe_loc_w),
  .spe_tap      (spe_tap_w),
  .cmd_valid    (cmd_valid),
  .bkpt_en      (bkpt_en),
  .pss_clr      (pss_clr)
);

// File: tb/tb_dbg_ctl_flag_regs.sv
`timescale 1ns/1ps
module tb_dbg_ctl_flag_regs;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tap_tlr, de_cmd_we, de_dme_we, de_dme, de_txc_clr, de_spe_set;
  logic [3:0] de_cmd;
  logic       tap_xfer_done, tap_spe_we, tap_spe_din, tap_rod;
  logic       bg_mode, test_mode_en, cpu_rd, cpu_wr, cpu_sel;
  logic [7:0] cpu_wdata;
  logic [7:0] rdata;
  logic [3:0] cmd_code;
  logic       cmd_valid, bkpt_en, pss_clr;

  int checks = 0;
  int fails  = 0;

  // Reference state
  int m_cmd, m_dme, m_txc, m_sloc, m_stap, m_cv, m_pss;

  always #2 clk = ~clk;

  dbg_ctl_flag_regs dut (
    .clk(clk), .rst_n(rst_n), .tap_tlr(tap_tlr),
    .de_cmd_we(de_cmd_we), .de_cmd(de_cmd), .de_dme_we(de_dme_we), .de_dme(de_dme),
    .de_txc_clr(de_txc_clr), .de_spe_set(de_spe_set), .tap_xfer_done(tap_xfer_done),
    .tap_spe_we(tap_spe_we), .tap_spe_din(tap_spe_din), .tap_rod(tap_rod),
    .bg_mode(bg_mode), .test_mode_en(test_mode_en), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata), .rdata(rdata), .cmd_code(cmd_code),
    .cmd_valid(cmd_valid), .bkpt_en(bkpt_en), .pss_clr(pss_clr)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_rdata();
    int v;
    if (!cpu_rd) return 0;
    if (cpu_sel) v = m_txc + 2 * ((m_sloc != 0 || m_stap != 0) ? 1 : 0);
    else         v = m_cmd + 128 * m_dme;
    return v;
  endfunction

  task automatic model_update();
    if (!rst_n || tap_tlr) begin
      m_cmd = 0; m_dme = 0; m_txc = 0; m_sloc = 0; m_stap = 0; m_cv = 0; m_pss = 0;
    end else begin
      m_cv = 0;
      if (de_cmd_we) begin
        m_cmd = int'(de_cmd);
        if (m_cmd <= 9 || (m_cmd == 10 && test_mode_en)) m_cv = 1;
      end
      if (de_dme_we && bg_mode) m_dme = int'(de_dme);
      if (tap_xfer_done) m_txc = 1;
      else if (cpu_wr && cpu_sel) m_txc = int'(cpu_wdata[0]);
      else if (de_txc_clr) m_txc = 0;
      m_pss = (cpu_wr && cpu_sel) ? 1 : 0;
      if (de_spe_set) m_sloc = 1;
      if (tap_rod) m_stap = 0;
      else if (tap_spe_we) m_stap = int'(tap_spe_din);
    end
  endtask

  task automatic clear_strobes();
    tap_tlr = 0; de_cmd_we = 0; de_dme_we = 0; de_txc_clr = 0; de_spe_set = 0;
    tap_xfer_done = 0; tap_spe_we = 0; tap_rod = 0; cpu_rd = 0; cpu_wr = 0;
  endtask

  // Called at a falling edge with inputs already set
  task automatic step(input string tag);
    #1;
    chk(tag, "rdata", int'(rdata), exp_rdata());
    chk("R9", "cmd_valid", int'(cmd_valid), m_cv);
    chk("R6", "pss_clr", int'(pss_clr), m_pss);
    chk("R4", "bkpt_en", int'(bkpt_en), m_dme);
    chk("R2", "cmd_code", int'(cmd_code), m_cmd);
    @(posedge clk);
    model_update();
    @(negedge clk);
    clear_strobes();
  endtask

  task automatic rd(input string tag, input logic sel);
    cpu_rd = 1; cpu_sel = sel; step(tag);
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 0; bg_mode = 0; test_mode_en = 0; cpu_sel = 0; cpu_wdata = 0;
    de_cmd = 0; de_dme = 0; tap_spe_din = 0;
    clear_strobes();
    m_cmd = 0; m_dme = 0; m_txc = 0; m_sloc = 0; m_stap = 0; m_cv = 0; m_pss = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    // R1: reset state of both registers
    rd("R1", 0); rd("R1", 1);

    // R2 / R9: command load and strobe
    de_cmd_we = 1; de_cmd = 4'b0001; step("R2");
    rd("R2", 0);
    // R9: every code, test mode off then on
    for (int tm = 0; tm < 2; tm++) begin
      test_mode_en = tm[0];
      for (int c = 0; c < 16; c++) begin
        de_cmd_we = 1; de_cmd = c[3:0]; step("R9");
        rd("R9", 0);
      end
    end
    // R9: back-to-back loads
    de_cmd_we = 1; de_cmd = 4'b0110; step("R9");
    de_cmd_we = 1; de_cmd = 4'b1100; step("R9");
    de_cmd_we = 1; de_cmd = 4'b0111; step("R9");
    // R2: CPU write to control register is ignored
    cpu_wr = 1; cpu_sel = 0; cpu_wdata = 8'hFF; step("R2");
    rd("R2", 0);
    // R3: reserved bits stay zero with everything else set
    bg_mode = 1; de_dme_we = 1; de_dme = 1; de_cmd_we = 1; de_cmd = 4'hF; step("R4");
    rd("R3", 0);
    // R4: enable held while background mode is off
    bg_mode = 0; de_dme_we = 1; de_dme = 0; step("R4");
    rd("R4", 0);
    bg_mode = 1; de_dme_we = 1; de_dme = 0; step("R4");
    rd("R4", 0);
    bg_mode = 1; de_dme_we = 1; de_dme = 1; step("R4");
    bg_mode = 0;

    // R5: transfer complete set, clear, collision
    tap_xfer_done = 1; step("R5");
    rd("R5", 1);
    de_txc_clr = 1; step("R5");
    rd("R5", 1);
    tap_xfer_done = 1; de_txc_clr = 1; step("R5");
    rd("R5", 1);
    tap_xfer_done = 1; cpu_wr = 1; cpu_sel = 1; cpu_wdata = 8'h00; step("R5");
    rd("R5", 1);
    // R6: CPU write to flag register, upper bits ignored, pulse
    cpu_wr = 1; cpu_sel = 1; cpu_wdata = 8'hFE; step("R6");
    rd("R6", 1);
    step("R6");
    cpu_wr = 1; cpu_sel = 1; cpu_wdata = 8'h01; step("R6");
    cpu_wr = 1; cpu_sel = 1; cpu_wdata = 8'h00; step("R6");
    rd("R6", 1);

    // R7 / R8: program enable OR and ROD
    tap_spe_we = 1; tap_spe_din = 1; step("R8");
    rd("R7", 1);
    tap_rod = 1; step("R8");
    rd("R8", 1);
    tap_spe_we = 1; tap_spe_din = 1; tap_rod = 1; step("R8");
    rd("R8", 1);
    cpu_wr = 1; cpu_sel = 1; cpu_wdata = 8'h02; step("R7");
    rd("R7", 1);
    de_spe_set = 1; step("R7");
    rd("R7", 1);
    tap_spe_we = 1; tap_spe_din = 1; step("R7");
    tap_rod = 1; step("R7");
    rd("R7", 1);

    // R10: read strobe low returns zero
    cpu_sel = 0; step("R10");
    cpu_sel = 1; step("R10");

    // R1: TAP reset over concurrent writes
    bg_mode = 1; de_dme_we = 1; de_dme = 1; step("R1");
    tap_xfer_done = 1; tap_spe_we = 1; tap_spe_din = 1; step("R1");
    tap_tlr = 1; de_cmd_we = 1; de_cmd = 4'b0011; cpu_wr = 1; cpu_sel = 1;
    cpu_wdata = 8'h01; tap_xfer_done = 1; step("R1");
    rd("R1", 0); rd("R1", 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule